// File: doc/BRIEF.md
# Multi-Cycle Integer Divider

This block divides a double-width or single-width integer by a single-width divisor and returns a single-width quotient and a single-width remainder on separate outputs. It supports unsigned and two's-complement signed operands. A caller presents the operands with a mode selection and pulses `start`. The block then runs a restoring shift-and-subtract loop with one iteration per divisor bit. After a fixed number of cycles it pulses `done`, and the results and flags are valid in that cycle.

All four modes have the same latency. The narrow modes form their dividend from the low word only. Signed division works on magnitudes and applies the signs at the end. The quotient is truncated toward zero and the remainder takes the dividend's sign. A zero divisor raises `divZero`. A quotient that cannot be represented in the result width raises `overflow`.

Top module: `iterDivider`

## Requirements
- R1: With `wideMode`=0 the dividend is `dividendLo` alone, sign-extended when `signedMode`=1 and zero-extended otherwise, and `dividendHi` has no effect on any output.
- R2: With `wideMode`=1 and `signedMode`=0 the dividend is the unsigned value {`dividendHi`,`dividendLo`}. When no flag is raised, `quotient` is floor(dividend/divisor) and `remainder` is dividend mod divisor.
- R3: With `signedMode`=1 the operands are two's complement. The quotient is truncated toward zero and the remainder equals dividend - quotient*divisor, carrying the sign of the dividend (or zero).
- R4: When `start` is sampled high while idle, `done` is high in the cycle that follows the W+1-th rising edge after the accepting edge. W is the divisor width. This latency is the same in all four modes.
- R5: `busy` is high in every cycle from the accepting edge until `done` rises, and `busy` is low in the `done` cycle.
- R6: `done` is high for exactly one cycle per accepted operation.
- R7: `start` has no effect while `busy` is high. The result is that of the accepted operands, and no further `done` follows.
- R8: When the divisor is zero, `divZero` is 1 and `overflow` is 0 in the `done` cycle. `quotient` and `remainder` are then unspecified.
- R9: When the divisor is non-zero and the true quotient lies outside the range of the result width, `overflow` is 1 in the `done` cycle. For unsigned results the range is 0..2^W-1. For signed results it is -2^(W-1)..2^(W-1)-1. Narrow unsigned division never overflows.
- R10: After reset, `busy`, `done`, `quotient`, `remainder`, `divZero` and `overflow` are all 0. The result outputs and flags change only in a `done` cycle and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation when idle |
| wideMode | input | 1 | 1: double-width dividend, 0: single-width dividend |
| signedMode | input | 1 | 1: two's-complement operands |
| dividendHi | input | W | Upper word of the double-width dividend |
| dividendLo | input | W | Lower word of the dividend |
| divisor | input | W | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | W | Quotient |
| remainder | output | W | Remainder |
| divZero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient does not fit in W bits |

## Verification
The hardest outcomes to reach from the ports are the signed boundary overflows. These are the most negative dividend divided by -1, and double-width dividends whose quotient magnitude is exactly 2^(W-1). The second case is legal only when the result is negative. Random operands at full width almost never land on these values. The bench therefore builds the divider at W=4 and sweeps every dividend and divisor in all four modes, so every boundary is covered. Each operation also varies the ignored high word and repeats `start` during the busy period.

// File: rtl/divPkg.sv
package divPkg;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } divStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN
  } divState_t;

endpackage

// File: rtl/divCtrl.sv
module divCtrl
  import divPkg::*;
#(
  parameter int W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output divStrobes_t strb,
  output logic        busy,
  output logic        done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  divState_t      state, stateNext;
  logic [CW-1:0]  iter;
  logic           lastIter;

  assign lastIter = (iter == CW'(W - 1));

  always_comb begin
    stateNext = state;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          stateNext = ST_RUN;
        end
      end
      ST_RUN: begin
        strb.step = 1'b1;
        if (lastIter) stateNext = ST_FIN;
      end
      ST_FIN: begin
        strb.finish = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      iter  <= '0;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strb.finish;
      if (strb.load)      iter <= '0;
      else if (strb.step) iter <= iter + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/divDatapath.sv
module divDatapath
  import divPkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  divStrobes_t   strb,
  input  logic          wideMode,
  input  logic          signedMode,
  input  logic [W-1:0]  dividendHi,
  input  logic [W-1:0]  dividendLo,
  input  logic [W-1:0]  divisor,
  output logic [W-1:0]  quotient,
  output logic [W-1:0]  remainder,
  output logic          divZero,
  output logic          overflow
);
  localparam int DW = 2 * W;

  // operand formation and magnitude extraction
  logic [DW-1:0] dvdFull, dvdMag;
  logic [W-1:0]  dsrMag;
  logic          dvdNeg, dsrNeg, hiGe;

  always_comb begin
    if (wideMode)        dvdFull = {dividendHi, dividendLo};
    else if (signedMode) dvdFull = {{W{dividendLo[W-1]}}, dividendLo};
    else                 dvdFull = {{W{1'b0}}, dividendLo};
    dvdNeg = signedMode & dvdFull[DW-1];
    dsrNeg = signedMode & divisor[W-1];
    dvdMag = dvdNeg ? (~dvdFull + 1'b1) : dvdFull;
    dsrMag = dsrNeg ? (~divisor + 1'b1) : divisor;
    hiGe   = (dvdMag[DW-1:W] >= dsrMag);
  end

  // iteration state
  logic [W-1:0] remQ, quoQ, divQ;
  logic         negDvdQ, negQuoQ, signedQ, hiGeQ, zeroQ;

  logic [W:0]   shifted, trial;
  logic         qBit;

  always_comb begin
    shifted = {remQ, quoQ[W-1]};
    trial   = shifted - {1'b0, divQ};
    qBit    = (shifted >= {1'b0, divQ});
  end

  // sign restoration and range check
  logic [W-1:0] quoFix, remFix;
  logic         sgnOvf, ovfNext;

  always_comb begin
    quoFix  = negQuoQ ? (~quoQ + 1'b1) : quoQ;
    remFix  = negDvdQ ? (~remQ + 1'b1) : remQ;
    sgnOvf  = signedQ & (negQuoQ ? (quoQ[W-1] & (|quoQ[W-2:0])) : quoQ[W-1]);
    ovfNext = ~zeroQ & (hiGeQ | sgnOvf);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ      <= '0;
      quoQ      <= '0;
      divQ      <= '0;
      negDvdQ   <= 1'b0;
      negQuoQ   <= 1'b0;
      signedQ   <= 1'b0;
      hiGeQ     <= 1'b0;
      zeroQ     <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      divZero   <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (strb.load) begin
        remQ    <= dvdMag[DW-1:W];
        quoQ    <= dvdMag[W-1:0];
        divQ    <= dsrMag;
        negDvdQ <= dvdNeg;
        negQuoQ <= dvdNeg ^ dsrNeg;
        signedQ <= signedMode;
        hiGeQ   <= hiGe;
        zeroQ   <= (divisor == '0);
      end else if (strb.step) begin
        remQ <= qBit ? trial[W-1:0] : shifted[W-1:0];
        quoQ <= {quoQ[W-2:0], qBit};
      end
      if (strb.finish) begin
        quotient  <= quoFix;
        remainder <= remFix;
        divZero   <= zeroQ;
        overflow  <= ovfNext;
      end
    end
  end

endmodule

// File: rtl/iterDivider.sv
module iterDivider
  import divPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         wideMode,
  input  logic         signedMode,
  input  logic [W-1:0] dividendHi,
  input  logic [W-1:0] dividendLo,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         divZero,
  output logic         overflow
);
  divStrobes_t strb;

  divCtrl #(.W(W)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .busy  (busy),
    .done  (done)
  );

  divDatapath #(.W(W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wideMode   (wideMode),
    .signedMode (signedMode),
    .dividendHi (dividendHi),
    .dividendLo (dividendLo),
    .divisor    (divisor),
    .quotient   (quotient),
    .remainder  (remainder),
    .divZero    (divZero),
    .overflow   (overflow)
  );

endmodule

// File: rtl/iterDividerChk.sv
module iterDividerChk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         wideMode,
  input logic         signedMode,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] quotient,
  input logic [W-1:0] remainder,
  input logic         divZero,
  input logic         overflow
);
  logic [7:0]   cyc;
  logic [W-1:0] capDiv;
  logic         capNarrowU;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cyc        <= '0;
      capDiv     <= '0;
      capNarrowU <= 1'b0;
    end else if (start && !busy) begin
      cyc        <= 8'd1;
      capDiv     <= divisor;
      capNarrowU <= !wideMode && !signedMode;
    end else if (busy) begin
      cyc <= cyc + 8'd1;
    end
  end

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cyc == 8'(W + 2)));

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (divZero == (capDiv == '0)) && !(divZero && overflow));

  // R9
  narrow_unsigned_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && capNarrowU) |-> !overflow);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(divZero) && $stable(overflow)));

endmodule

bind iterDivider iterDividerChk #(.W(W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .wideMode   (wideMode),
  .signedMode (signedMode),
  .divisor    (divisor),
  .busy       (busy),
  .done       (done),
  .quotient   (quotient),
  .remainder  (remainder),
  .divZero    (divZero),
  .overflow   (overflow)
);

// File: tb/sim_iterDivider.sv
`timescale 1ns/1ps
module sim_iterDivider;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rstN;
  logic         start;
  logic         wideMode, signedMode;
  logic [W-1:0] dividendHi, dividendLo, divisor;
  logic         busy, done, divZero, overflow;
  logic [W-1:0] quotient, remainder;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  iterDivider #(.W(W)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .wideMode(wideMode),
    .signedMode(signedMode), .dividendHi(dividendHi), .dividendLo(dividendLo),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .divZero(divZero), .overflow(overflow)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic runOp(input bit wide, input bit sgn, input logic [W-1:0] hi,
                       input logic [W-1:0] lo, input logic [W-1:0] d, input bit hammer);
    int n, dv, q, r, cycles;
    bit expZero, expOvf, busyOk;
    string tag;
    logic [W-1:0] qHold, rHold;
    n = wide ? int'({hi, lo}) : int'(lo);
    if (sgn && wide && hi[W-1]) n -= 2 ** (2 * W);
    if (sgn && !wide && lo[W-1]) n -= 2 ** W;
    dv = int'(d);
    if (sgn && d[W-1]) dv -= 2 ** W;
    expZero = (dv == 0);
    q = expZero ? 0 : n / dv;
    r = expZero ? 0 : n % dv;
    expOvf = !expZero && (sgn ? (q < -(2 ** (W - 1)) || q > 2 ** (W - 1) - 1) : (q > 2 ** W - 1));
    tag = !wide ? "R1" : (sgn ? "R3" : "R2");

    @(negedge clk);
    wideMode = wide; signedMode = sgn; dividendHi = hi; dividendLo = lo; divisor = d;
    start = 1'b1;
    @(negedge clk);
    cycles = 1;
    busyOk = busy;
    if (hammer) begin
      dividendHi = ~hi; dividendLo = ~lo; divisor = d ^ 4'h5; signedMode = ~sgn;
    end else start = 1'b0;
    while (!done && cycles < 40) begin
      @(negedge clk);
      cycles++;
      if (cycles >= 3) start = 1'b0;
      if (!done && !busy) busyOk = 0;
    end
    check(cycles == W + 2, "R4 latency", cycles, W + 2);
    check(busyOk && !busy, "R5 busy", int'(busyOk), 1);
    check(divZero == expZero, "R8 divZero", int'(divZero), int'(expZero));
    check(overflow == expOvf, "R9 overflow", int'(overflow), int'(expOvf));
    if (!expZero && !expOvf) begin
      check(quotient == W'(q), {tag, " quotient"}, int'(quotient), q);
      check(remainder == W'(r), {tag, " remainder"}, int'(remainder), r);
    end
    qHold = quotient; rHold = remainder;
    @(negedge clk);
    check(!done, "R6 done pulse", int'(done), 0);
    check(quotient == qHold && remainder == rHold, "R10 hold", int'(quotient), int'(qHold));
    if (hammer) begin
      bit extra;
      extra = 0;
      repeat (W + 3) begin
        @(negedge clk);
        if (done || busy) extra = 1;
      end
      check(!extra, "R7 no extra op", int'(extra), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; start = 1'b0; wideMode = 1'b0; signedMode = 1'b0;
    dividendHi = '0; dividendLo = '0; divisor = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !divZero && !overflow, "R10 reset flags", int'({busy, done, divZero, overflow}), 0);
    check(quotient == '0 && remainder == '0, "R10 reset results", int'({quotient, remainder}), 0);

    // R7: start held high with different operands while busy
    runOp(1'b1, 1'b1, 4'hF, 4'h9, 4'h3, 1'b1);
    runOp(1'b0, 1'b0, 4'h0, 4'hD, 4'h4, 1'b1);

    for (int sgn = 0; sgn < 2; sgn++) begin
      for (int hi = 0; hi < 16; hi++)
        for (int lo = 0; lo < 16; lo++)
          for (int d = 0; d < 16; d++)
            runOp(1'b1, sgn[0], W'(hi), W'(lo), W'(d), 1'b0);
      // R1: narrow modes with a varying high word that must be ignored
      for (int lo = 0; lo < 16; lo++)
        for (int d = 0; d < 16; d++)
          runOp(1'b0, sgn[0], W'(lo ^ d ^ 9), W'(lo), W'(d), 1'b0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule